// File: doc/BRIEF.md
# Conditional Configuration Replay Sequencer

This block replays a byte-coded instruction stream from a 2048-byte nonvolatile store into a device register file. After a start strobe it reads the store from address 0, one byte per read handshake. Data instructions become register writes. Single-byte instructions do one of four things: set or clear condition tags, pulse an I/O-update or calibrate strobe, or end the run. Every data transfer and every pulse is checked against a checksum or gated by a condition.

Several setups can share one image. Tag opcodes add conditions to an active set, and that set grows until an explicit clear. While any tag is active, gated instructions run only if the 5-bit condition latched at start is one of the active tags. With an empty set, everything runs. A caller picks one setup by driving the condition value and pulsing start. It then waits for `done` and reads `load_err`.

Top module: `cfg_replay_seq`

## Requirements
- R1: After reset, busy, done, load_err, reg_we, io_update, calibrate and rom_req are all low.
- R2: A start pulse while idle latches cond_sel, clears all tags, lowers done and load_err, raises busy and begins fetching at store address 0. A start pulse while busy has no effect on the run.
- R3: Opcodes 0x00–0x7F, except 0x0A, are data instructions that carry N = opcode+1 data bytes. The opcode is followed by a target address, high byte first, then the N data bytes, then a checksum byte. Each data byte is written with reg_we to the target address plus its index, in order.
- R4: The checksum byte must equal the 8-bit modular sum of the opcode, both address bytes and all data bytes. On a mismatch the run stops: busy falls and both done and load_err rise, and no later byte has any effect.
- R5: Opcode 0xB0 clears all tags. While no tag is active, every gated instruction runs.
- R6: Opcodes 0xB1–0xCF add tags 1–31, and the tags accumulate. While any tag is active, a gated instruction runs only if the latched condition is an active tag. Condition 0 then never matches.
- R7: A gated-off data instruction writes nothing. The read pointer still advances by N+4 bytes, and its checksum is still checked.
- R8: Opcode 0x80 gives a one-cycle io_update pulse and opcode 0x0A gives a one-cycle calibrate pulse. Both are gated like data.
- R9: Opcode 0xFE and the unassigned opcodes 0x81–0xAF and 0xD0–0xFD are one-byte no-ops.
- R10: Opcode 0xFF ends the run: busy falls and done rises with load_err low. done and load_err hold until the next accepted start.
- R11: A byte read at address 2047 that is not an end opcode has no effect and aborts the run with load_err. An end opcode at 2047 ends the run cleanly.
- R12: At most one of reg_we, io_update and calibrate is high in any cycle, and each is high only while busy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a replay run |
| cond_sel | input | 5 | Selected condition, latched at start |
| rom_addr | output | 11 | Store read address |
| rom_req | output | 1 | Store read request, one cycle |
| rom_data | input | 8 | Store read data |
| rom_valid | input | 1 | rom_data holds the requested byte |
| reg_addr | output | 16 | Register write address |
| reg_wdata | output | 8 | Register write data |
| reg_we | output | 1 | Register write strobe |
| io_update | output | 1 | I/O-update pulse |
| calibrate | output | 1 | Calibrate pulse |
| busy | output | 1 | Run in progress |
| done | output | 1 | Run has finished |
| load_err | output | 1 | Run ended on a checksum mismatch or on the store limit |

## Verification
Two events can fall on the same byte: the store-limit abort and the normal handling of the byte at address 2047. The bench fills the store with pause bytes and places either an end opcode or an I/O-update opcode at the last address. In the first case the run must end cleanly. In the second case no pulse may appear and the run must abort with an error. A checksum mismatch on a gated-off instruction is a second collision. Skipping must not hide the error, and no write may leak through.

// File: rtl/cfg_replay_seq.sv
module cfg_replay_seq #(
  parameter int ST_AW  = 11,
  parameter int COND_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [COND_W-1:0] cond_sel,
  output logic [ST_AW-1:0]  rom_addr,
  output logic              rom_req,
  input  logic [7:0]        rom_data,
  input  logic              rom_valid,
  output logic [15:0]       reg_addr,
  output logic [7:0]        reg_wdata,
  output logic              reg_we,
  output logic              io_update,
  output logic              calibrate,
  output logic              busy,
  output logic              done,
  output logic              load_err
);
  localparam int NTAG = 1 << COND_W;
  localparam logic [ST_AW-1:0] LAST = '1;
  localparam logic [8:0] TAG_HI = 9'(9'h0B0 + NTAG - 1);

  typedef enum logic [1:0] {S_IDLE, S_ISSUE, S_WAIT} st_t;
  typedef enum logic [2:0] {P_OP, P_AHI, P_ALO, P_DAT, P_SUM} ph_t;

  st_t st;
  ph_t ph;
  logic [ST_AW-1:0]  ptr;
  logic [6:0]        cnt;
  logic [7:0]        sum;
  logic              skip;
  logic [NTAG-1:0]   tags;
  logic [COND_W-1:0] cond_q;
  logic [15:0]       addr_q;

  assign rom_req  = (st == S_ISSUE);
  assign rom_addr = ptr;

  wire gate     = (tags == '0) || tags[cond_q];
  wire is_op    = (ph == P_OP);
  wire is_data  = is_op && !rom_data[7] && (rom_data != 8'h0A);
  wire is_tag   = is_op && ({1'b0, rom_data} > 9'h0B0) && ({1'b0, rom_data} <= TAG_HI);
  wire [COND_W-1:0] tag_idx = rom_data[COND_W-1:0] - COND_W'(8'hB0);
  wire hit_end  = is_op && (rom_data == 8'hFF);
  wire bad_sum  = (ph == P_SUM) && (rom_data != sum);
  wire finish   = hit_end || bad_sum || (ptr == LAST);
  wire take     = (st == S_WAIT) && rom_valid;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; ph <= P_OP; ptr <= '0; cnt <= '0; sum <= '0; skip <= 1'b0;
      tags <= '0; cond_q <= '0; addr_q <= '0;
      reg_addr <= '0; reg_wdata <= '0; reg_we <= 1'b0;
      io_update <= 1'b0; calibrate <= 1'b0;
      busy <= 1'b0; done <= 1'b0; load_err <= 1'b0;
    end else begin
      reg_we <= 1'b0; io_update <= 1'b0; calibrate <= 1'b0;
      case (st)
        S_IDLE: if (start) begin
          st <= S_ISSUE; ph <= P_OP; ptr <= '0; tags <= '0;
          cond_q <= cond_sel; busy <= 1'b1; done <= 1'b0; load_err <= 1'b0;
        end
        S_ISSUE: st <= S_WAIT;
        S_WAIT: if (take) begin
          if (finish) begin
            st <= S_IDLE; busy <= 1'b0; done <= 1'b1; load_err <= !hit_end;
          end else begin
            st  <= S_ISSUE;
            ptr <= ptr + 1'b1;
            case (ph)
              P_OP: begin
                if (is_data) begin
                  ph <= P_AHI; cnt <= rom_data[6:0]; sum <= rom_data; skip <= !gate;
                end else if (rom_data == 8'h0A) calibrate <= gate;
                else if (rom_data == 8'h80) io_update <= gate;
                else if (rom_data == 8'hB0) tags <= '0;
                else if (is_tag) tags[tag_idx] <= 1'b1;
              end
              P_AHI: begin addr_q[15:8] <= rom_data; sum <= sum + rom_data; ph <= P_ALO; end
              P_ALO: begin addr_q[7:0]  <= rom_data; sum <= sum + rom_data; ph <= P_DAT; end
              P_DAT: begin
                reg_we    <= !skip;
                reg_addr  <= addr_q;
                reg_wdata <= rom_data;
                addr_q    <= addr_q + 16'd1;
                sum       <= sum + rom_data;
                if (cnt == '0) ph <= P_SUM;
                else cnt <= cnt - 7'd1;
              end
              default: ph <= P_OP;
            endcase
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  assert_strobe_busy_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we || io_update || calibrate) |-> busy);
  assert_one_strobe_R12: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({reg_we, io_update, calibrate}) <= 1);
  assert_done_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);
  assert_err_done_R4: assert property (@(posedge clk) disable iff (!rst_n)
    load_err |-> done);
  assert_req_busy_R2: assert property (@(posedge clk) disable iff (!rst_n)
    rom_req |-> busy);
  assert_io_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    io_update |=> !io_update);
  assert_cal_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    calibrate |=> !calibrate);
  assert_addr_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && $past(reg_we, 2) && $past(busy, 2)) |-> (reg_addr == $past(reg_addr, 2) + 16'd1));
endmodule

// File: tb/cfg_replay_seq_bench.sv
module cfg_replay_seq_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [4:0] cond_sel = '0;
  logic [10:0] rom_addr;
  logic rom_req;
  logic [7:0] rom_data;
  logic rom_valid;
  logic [15:0] reg_addr;
  logic [7:0] reg_wdata;
  logic reg_we, io_update, calibrate, busy, done, load_err;

  always #4 clk = ~clk;

  cfg_replay_seq u_cfg_replay_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .cond_sel(cond_sel),
    .rom_addr(rom_addr), .rom_req(rom_req), .rom_data(rom_data), .rom_valid(rom_valid),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_we(reg_we),
    .io_update(io_update), .calibrate(calibrate),
    .busy(busy), .done(done), .load_err(load_err));

  logic [7:0] mem [2048];
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin rom_valid <= 1'b0; rom_data <= '0; end
    else begin rom_valid <= rom_req; rom_data <= mem[rom_addr]; end
  end

  int checks = 0, errors = 0, cycles = 0;
  int nwr, ncal, nio;
  logic [23:0] sig;
  logic [15:0] last_a;
  logic [7:0]  last_d;

  always @(negedge clk) begin
    cycles <= cycles + 1;
    if (reg_we) begin
      nwr <= nwr + 1; sig <= sig + {reg_addr, reg_wdata};
      last_a <= reg_addr; last_d <= reg_wdata;
    end
    if (io_update) nio <= nio + 1;
    if (calibrate) ncal <= ncal + 1;
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic fill(input logic [7:0] b);
    for (int i = 0; i < 2048; i++) mem[i] = b;
  endtask

  task automatic run(input logic [4:0] c, input bit glitch);
    @(negedge clk);
    nwr = 0; nio = 0; ncal = 0; sig = '0;
    cond_sel = c; start = 1'b1;
    @(negedge clk);
    start = 1'b0; cond_sel = ~c;
    for (int k = 0; k < 10000 && !done; k++) begin
      @(negedge clk);
      if (glitch && k == 12) start = 1'b1;
      else start = 1'b0;
    end
    start = 1'b0;
    if (!done) chk("R10 run completes", 0, 1);
    @(negedge clk);
  endtask

  localparam logic [7:0] IMG [26] = '{
    8'h01, 8'h01, 8'h00, 8'hAA, 8'hBB, 8'h67,
    8'hB1,
    8'h00, 8'h04, 8'h00, 8'h11, 8'h15,
    8'hB2, 8'hB3,
    8'h00, 8'h05, 8'h00, 8'h22, 8'h27,
    8'h0A, 8'hB0, 8'h80, 8'hFE, 8'h0A, 8'h90, 8'hFF};

  typedef struct packed {
    logic [4:0]  cond;
    logic [7:0]  nwr;
    logic [23:0] sig;
    logic [7:0]  ncal;
    logic [7:0]  nio;
  } vec_t;

  localparam vec_t VEC [5] = '{
    '{5'd0,  8'd2, 24'h020265, 8'd1, 8'd1},
    '{5'd1,  8'd4, 24'h0B0298, 8'd2, 8'd1},
    '{5'd2,  8'd3, 24'h070287, 8'd2, 8'd1},
    '{5'd3,  8'd3, 24'h070287, 8'd2, 8'd1},
    '{5'd31, 8'd2, 24'h020265, 8'd1, 8'd1}};

  initial begin
    while (cycles < 150000) @(negedge clk);
    chk("watchdog", 0, 1);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    fill(8'hFF);
    repeat (3) @(negedge clk);
    chk("R1 busy", busy, 0);   chk("R1 done", done, 0);
    chk("R1 load_err", load_err, 0); chk("R1 reg_we", reg_we, 0);
    chk("R1 rom_req", rom_req, 0);   chk("R1 pulses", io_update | calibrate, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 idle after release", busy | done | rom_req, 0);

    for (int i = 0; i < 26; i++) mem[i] = IMG[i];
    foreach (VEC[v]) begin
      run(VEC[v].cond, 1'b0);
      chk("R10 done", done, 1);        chk("R10 no error", load_err, 0);
      chk("R10 busy low", busy, 0);
      chk("R3 R6 write count", nwr, VEC[v].nwr);
      chk("R3 R5 R6 write signature", sig, VEC[v].sig);
      chk("R8 calibrate count", ncal, VEC[v].ncal);
      chk("R8 R9 io_update count", nio, VEC[v].nio);
    end

    run(5'd1, 1'b1);
    chk("R2 start while busy ignored, writes", nwr, 4);
    chk("R2 start while busy ignored, signature", sig, 24'h0B0298);
    repeat (5) @(negedge clk);
    chk("R10 done held", done, 1);

    fill(8'hFF);
    mem[0] = 8'hB1;
    mem[1] = 8'h00; mem[2] = 8'h00; mem[3] = 8'h10; mem[4] = 8'h33; mem[5] = 8'h00;
    mem[6] = 8'h80;
    run(5'd5, 1'b0);
    chk("R7 skipped data writes nothing", nwr, 0);
    chk("R4 R7 skipped bad checksum flagged", load_err, 1);
    chk("R4 abort stops before io_update", nio, 0);
    run(5'd1, 1'b0);
    chk("R4 write before checksum", nwr, 1);
    chk("R4 mismatch flagged", load_err, 1);
    chk("R4 done on abort", done, 1);
    mem[5] = 8'h43;
    run(5'd5, 1'b0);
    chk("R7 skipped good checksum, io gated off", nio, 0);
    chk("R7 skip advances N+4", load_err, 0);

    fill(8'hFF);
    begin
      logic [7:0] s;
      mem[0] = 8'h7F; mem[1] = 8'h12; mem[2] = 8'hF0;
      s = 8'h7F + 8'h12 + 8'hF0;
      for (int i = 0; i < 128; i++) begin mem[3+i] = 8'(i); s = s + 8'(i); end
      mem[131] = s;
    end
    run(5'd0, 1'b0);
    chk("R3 max length writes", nwr, 128);
    chk("R3 final address", last_a, 16'h136F);
    chk("R3 final data", last_d, 8'h7F);
    chk("R3 long checksum ok", load_err, 0);

    fill(8'hFE);
    mem[100] = 8'hC5; mem[101] = 8'hD0; mem[102] = 8'hA7;
    run(5'd0, 1'b0);
    chk("R11 limit abort error", load_err, 1);
    chk("R9 R11 no-ops do nothing", nwr + nio + ncal, 0);
    mem[2047] = 8'hFF;
    run(5'd0, 1'b0);
    chk("R11 end at last address clean", load_err, 0);
    chk("R11 end at last address done", done, 1);
    mem[2047] = 8'h80;
    run(5'd0, 1'b0);
    chk("R11 last byte no pulse", nio, 0);
    chk("R11 last byte aborts", load_err, 1);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule